// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Promotion

This block gathers the interrupt requests of a small CPU core and decides which one is presented next. It has 27 maskable sources and one non-maskable external request. Source 1 comes from an active-low external pin. That pin is either level sensitive or falling-edge sensitive; in edge mode a falling edge is latched. Sources 2 to 27 arrive as peripheral flag bits. Each maskable source has a local enable and is held off by a global I mask. The non-maskable request is held off only by a global X mask. The block keeps both mask bits and gives software a write port to change them. Software may clear X, but once X is clear it cannot set it again.

By default a lower source index wins. Software can promote one maskable source above all other maskable sources. To do so it writes that source's vector low byte into a priority select register. The non-maskable request always outranks every maskable source.

The arbitration is wrapped in a two-state machine:
- `ST_IDLE` watches the resolved winner. The transition *post* (winner valid) captures the vector low byte and the source index and moves to `ST_POSTED`.
- `ST_POSTED` holds `irq_req` high with frozen outputs. The transition *take* (ack) returns to `ST_IDLE`. On take, the mask bits are set and, when source 1 is taken, the edge latch is cleared.

Top module: `pic_promo_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `i_mask` and `x_mask` are both 1, and `prio_sel` reads 0xF2, which selects source 1.
- R2: A maskable source k is pending only when its request is present, its enable `src_en[k-1]` is 1 and `i_mask` is 0. Source k's request is `src_flag[k-2]` for k of 2 or more, and the pin condition for k = 1.
- R3: Among pending maskable sources with no promotion in effect, the lowest index wins. `src_id` equals the index and `vector_lo` equals 0xF4 minus twice the index (source 3 gives 0xEE, source 27 gives 0xBE).
- R4: Writing a source's vector low byte to `prio_sel` through `sel_we`/`sel_wdata` makes that source win over all other pending maskable sources. For example, 0xDE promotes source 11.
- R5: A write to `prio_sel` while `i_mask` is 0 is ignored, and `prio_sel` keeps its value. Bit 0 of `prio_sel` always reads 0.
- R6: A stored value that matches no maskable vector (for example 0x20) turns promotion off, so the default order of R3 applies.
- R7: With `irq_edge_mode` = 0, source 1 is requested while `irq_n` is low.
- R8: With `irq_edge_mode` = 1, a falling edge of `irq_n` is latched. The request stays after the pin returns high, and the latch is cleared when source 1 is acknowledged.
- R9: A low `xirq_n` with `x_mask` = 0 wins regardless of `i_mask` or any maskable source. It gives `src_id` 0 and `vector_lo` 0xF4. With `x_mask` = 1 it gives no request.
- R10: A mask write (`mask_we`) loads `i_mask` from `mask_wr_i` and can clear `x_mask`, but it cannot set `x_mask` once `x_mask` is 0.
- R11: Acknowledging any request sets `i_mask`. Acknowledging the non-maskable request also sets `x_mask`.
- R12: The outputs are registered. While `irq_req` is high and `ack` is low, `vector_lo` and `src_id` do not change. `irq_req` falls in the cycle after `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | External maskable pin, active low (source 1) |
| irq_edge_mode | input | 1 | 0 = level sensitive, 1 = falling-edge sensitive |
| xirq_n | input | 1 | Non-maskable external request, active low |
| src_flag | input | 26 | Request flags for sources 2..27 (bit j is source j+2) |
| src_en | input | 27 | Local enables for sources 1..27 (bit j is source j+1) |
| mask_we | input | 1 | Write strobe for the global mask bits |
| mask_wr_i | input | 1 | Value written to the I mask |
| mask_wr_x | input | 1 | Value written to the X mask (can only clear it) |
| sel_we | input | 1 | Write strobe for the priority select register |
| sel_wdata | input | 8 | Vector low byte of the source to promote |
| ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Request to the CPU |
| vector_lo | output | 8 | Vector low byte of the presented source |
| src_id | output | 5 | Index of the presented source (0 = non-maskable) |
| i_mask | output | 1 | Global maskable-interrupt mask |
| x_mask | output | 1 | Global non-maskable-request mask |
| prio_sel | output | 8 | Priority select register contents |

## Verification
A wrong mask bit, select value or edge latch inside this block has a predictable effect at the ports. It either starts a request that should not exist, or it presents the wrong index and vector one clock after the inputs that should have produced the correct one. The bench carries a behavioural model that advances on every rising edge and compares every output on every falling edge. A corrupted state therefore shows up within the cycle in which it first affects `irq_req`, `src_id`, `vector_lo`, `i_mask`, `x_mask` or `prio_sel`. The directed steps deliberately leave latched or held state in place and then observe it later, for example an edge latched while I is set, or a request held across changing flags.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_POSTED = 1'b1
    } pic_state_e;

    // Vector low byte of maskable source idx, counted down from the base in steps of two
    function automatic logic [7:0] vec_of(input logic [7:0] base, input int unsigned idx);
        return base - 8'(idx << 1);
    endfunction

endpackage

// File: rtl/pic_irq_cond.sv
module pic_irq_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic active
);
    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (edge_mode) begin
                latch_q <= fall | (latch_q & ~clr);
            end else begin
                latch_q <= 1'b0;
            end
        end
    end

    assign active = edge_mode ? latch_q : ~pin_n;
endmodule

// File: rtl/pic_sel_reg.sv
module pic_sel_reg
    import pic_pkg::*;
#(
    parameter int          NUM_SRC  = 27,
    parameter int          ID_W     = 5,
    parameter logic [7:0]  VEC_BASE = 8'hF4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      wdata,
    input  logic            i_mask,
    output logic [7:0]      sel_q,
    output logic [ID_W-1:0] promo_idx
);
    localparam logic [7:0] SEL_RST = vec_of(VEC_BASE, 1);

    logic [6:0] sel_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_bits <= SEL_RST[7:1];
        end else if (we && i_mask) begin
            sel_bits <= wdata[7:1];
        end
    end

    assign sel_q = {sel_bits, 1'b0};

    always_comb begin
        promo_idx = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (sel_q == vec_of(VEC_BASE, k)) begin
                promo_idx = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
#(
    parameter int          NUM_SRC  = 27,
    parameter int          ID_W     = 5,
    parameter logic [7:0]  VEC_BASE = 8'hF4
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic               xirq_act,
    input  logic [ID_W-1:0]    promo_idx,
    output logic               win_valid,
    output logic [ID_W-1:0]    win_id,
    output logic [7:0]         win_vec
);
    logic            low_hit;
    logic [ID_W-1:0] low_id;
    logic            pro_hit;

    always_comb begin
        low_hit = 1'b0;
        low_id  = '0;
        for (int k = NUM_SRC; k >= 1; k--) begin
            if (pend[k-1]) begin
                low_hit = 1'b1;
                low_id  = ID_W'(k);
            end
        end
        pro_hit = 1'b0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (pend[k-1] && (promo_idx == ID_W'(k))) begin
                pro_hit = 1'b1;
            end
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_vec   = VEC_BASE;
        if (xirq_act) begin
            win_valid = 1'b1;
            win_id    = '0;
            win_vec   = VEC_BASE;
        end else if (pro_hit) begin
            win_valid = 1'b1;
            win_id    = promo_idx;
            win_vec   = vec_of(VEC_BASE, int'(promo_idx));
        end else if (low_hit) begin
            win_valid = 1'b1;
            win_id    = low_id;
            win_vec   = vec_of(VEC_BASE, int'(low_id));
        end
    end
endmodule

// File: rtl/pic_gmask.sv
module pic_gmask (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wr_i,
    input  logic wr_x,
    input  logic take,
    input  logic take_x,
    output logic i_q,
    output logic x_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= 1'b1;
            x_q <= 1'b1;
        end else begin
            if (take) begin
                i_q <= 1'b1;
            end else if (we) begin
                i_q <= wr_i;
            end
            if (take_x) begin
                x_q <= 1'b1;
            end else if (we) begin
                x_q <= x_q & wr_x;
            end
        end
    end
endmodule

// File: rtl/pic_promo_ctrl.sv
module pic_promo_ctrl
    import pic_pkg::*;
#(
    parameter int          NUM_SRC  = 27,
    parameter int          ID_W     = $clog2(NUM_SRC + 1),
    parameter logic [7:0]  VEC_BASE = 8'hF4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_n,
    input  logic               irq_edge_mode,
    input  logic               xirq_n,
    input  logic [NUM_SRC-2:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               mask_we,
    input  logic               mask_wr_i,
    input  logic               mask_wr_x,
    input  logic               sel_we,
    input  logic [7:0]         sel_wdata,
    input  logic               ack,
    output logic               irq_req,
    output logic [7:0]         vector_lo,
    output logic [ID_W-1:0]    src_id,
    output logic               i_mask,
    output logic               x_mask,
    output logic [7:0]         prio_sel
);
    localparam logic [ID_W-1:0] PIN_ID = ID_W'(1);

    pic_state_e state_q, state_d;

    logic               pin_active;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] pend;
    logic [ID_W-1:0]    promo_idx;
    logic               win_valid;
    logic [ID_W-1:0]    win_id;
    logic [7:0]         win_vec;
    logic               take, take_x, clr_pin;
    logic [7:0]         vec_q;
    logic [ID_W-1:0]    id_q;

    assign take    = (state_q == ST_POSTED) && ack;
    assign take_x  = take && (id_q == '0);
    assign clr_pin = take && (id_q == PIN_ID);

    pic_irq_cond u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (irq_n),
        .edge_mode (irq_edge_mode),
        .clr       (clr_pin),
        .active    (pin_active)
    );

    pic_gmask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wr_i   (mask_wr_i),
        .wr_x   (mask_wr_x),
        .take   (take),
        .take_x (take_x),
        .i_q    (i_mask),
        .x_q    (x_mask)
    );

    pic_sel_reg #(
        .NUM_SRC  (NUM_SRC),
        .ID_W     (ID_W),
        .VEC_BASE (VEC_BASE)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sel_we),
        .wdata     (sel_wdata),
        .i_mask    (i_mask),
        .sel_q     (prio_sel),
        .promo_idx (promo_idx)
    );

    assign raw_req[0] = pin_active;
    for (genvar g = 1; g < NUM_SRC; g++) begin : g_flag
        assign raw_req[g] = src_flag[g-1];
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        assign pend[g] = raw_req[g] & src_en[g] & ~i_mask;
    end

    pic_resolver #(
        .NUM_SRC  (NUM_SRC),
        .ID_W     (ID_W),
        .VEC_BASE (VEC_BASE)
    ) u_res (
        .pend      (pend),
        .xirq_act  (~xirq_n & ~x_mask),
        .promo_idx (promo_idx),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_vec   (win_vec)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_POSTED;
            ST_POSTED: if (ack)       state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output registers, loaded on the post transition only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            id_q  <= '0;
        end else if ((state_q == ST_IDLE) && win_valid) begin
            vec_q <= win_vec;
            id_q  <= win_id;
        end
    end

    assign irq_req   = (state_q == ST_POSTED);
    assign vector_lo = vec_q;
    assign src_id    = id_q;
endmodule

// File: rtl/pic_promo_ctrl_chk.sv
module pic_promo_ctrl_chk #(
    parameter int ID_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack,
    input logic            sel_we,
    input logic            irq_req,
    input logic [7:0]      vector_lo,
    input logic [ID_W-1:0] src_id,
    input logic            i_mask,
    input logic            x_mask,
    input logic [7:0]      prio_sel
);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !ack |=> irq_req && $stable(vector_lo) && $stable(src_id));

    p_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && ack |=> !irq_req);

    p_take_i_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && ack |=> i_mask);

    p_take_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && ack && (src_id == '0) |=> x_mask);

    p_x_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !x_mask && !(irq_req && ack && (src_id == '0)) |=> !x_mask);

    p_sel_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we && !i_mask |=> $stable(prio_sel));

    p_sel_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prio_sel[0] == 1'b0);

    p_xvec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && (src_id == '0) |-> vector_lo == 8'hF4);

    p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) && (src_id != '0) |-> $past(!i_mask));
endmodule

bind pic_promo_ctrl pic_promo_ctrl_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .sel_we    (sel_we),
    .irq_req   (irq_req),
    .vector_lo (vector_lo),
    .src_id    (src_id),
    .i_mask    (i_mask),
    .x_mask    (x_mask),
    .prio_sel  (prio_sel)
);

// File: tb/pic_promo_ctrl_tb.sv
module pic_promo_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 27;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_n = 1'b1;
    logic            irq_edge_mode = 1'b0;
    logic            xirq_n = 1'b1;
    logic [NSRC-2:0] src_flag = '0;
    logic [NSRC-1:0] src_en = '0;
    logic            mask_we = 1'b0;
    logic            mask_wr_i = 1'b0;
    logic            mask_wr_x = 1'b0;
    logic            sel_we = 1'b0;
    logic [7:0]      sel_wdata = '0;
    logic            ack = 1'b0;
    logic            irq_req;
    logic [7:0]      vector_lo;
    logic [4:0]      src_id;
    logic            i_mask;
    logic            x_mask;
    logic [7:0]      prio_sel;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_promo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_edge_mode(irq_edge_mode),
        .xirq_n(xirq_n), .src_flag(src_flag), .src_en(src_en),
        .mask_we(mask_we), .mask_wr_i(mask_wr_i), .mask_wr_x(mask_wr_x),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .ack(ack),
        .irq_req(irq_req), .vector_lo(vector_lo), .src_id(src_id),
        .i_mask(i_mask), .x_mask(x_mask), .prio_sel(prio_sel)
    );

    // Behavioural reference model
    bit m_i, m_x, m_req, m_prev, m_latch;
    int m_sel, m_vec, m_src;

    function automatic bit req_of(int k);
        if (k == 1) return irq_edge_mode ? m_latch : !irq_n;
        return src_flag[k-2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_i = 1; m_x = 1; m_req = 0; m_prev = 1; m_latch = 0;
            m_sel = 'hF2; m_vec = 0; m_src = 0;
        end else begin
            int win; int promo; bit took; bit n_i, n_x, n_latch;
            win = -1; promo = 0;
            for (int k = 1; k <= NSRC; k++)
                if (244 - 2*k == m_sel) promo = k;
            if (!xirq_n && !m_x) win = 0;
            else if (!m_i) begin
                if (promo != 0 && req_of(promo) && src_en[promo-1]) win = promo;
                else
                    for (int k = NSRC; k >= 1; k--)
                        if (req_of(k) && src_en[k-1]) win = k;
            end
            took = m_req && ack;
            n_i = took ? 1'b1 : (mask_we ? mask_wr_i : m_i);
            n_x = (took && m_src == 0) ? 1'b1 : (mask_we ? (m_x & mask_wr_x) : m_x);
            n_latch = irq_edge_mode ? ((m_prev && !irq_n) || (m_latch && !(took && m_src == 1))) : 1'b0;
            if (sel_we && m_i) m_sel = sel_wdata & 8'hFE;
            if (took) m_req = 0;
            else if (!m_req && win >= 0) begin
                m_req = 1; m_src = win; m_vec = (244 - 2*win) & 255;
            end
            m_i = n_i; m_x = n_x; m_latch = n_latch; m_prev = irq_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " model irq_req"}, irq_req, m_req);
            chk({cur_req, " model i_mask"}, i_mask, m_i);
            chk({cur_req, " model x_mask"}, x_mask, m_x);
            chk({cur_req, " model prio_sel"}, prio_sel, m_sel);
            if (m_req) begin
                chk({cur_req, " model src_id"}, src_id, m_src);
                chk({cur_req, " model vector_lo"}, vector_lo, m_vec);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mask(bit wi, bit wx);
        mask_we = 1; mask_wr_i = wi; mask_wr_x = wx;
        step(1);
        mask_we = 0;
    endtask

    task automatic wr_sel(int v);
        sel_we = 1; sel_wdata = 8'(v);
        step(1);
        sel_we = 0;
    endtask

    task automatic do_ack();
        ack = 1;
        step(1);
        ack = 0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 i_mask", i_mask, 1);
        chk("R1 x_mask", x_mask, 1);
        chk("R1 prio_sel", prio_sel, 'hF2);

        // R2 gating by I and local enable
        cur_req = "R2";
        src_flag[1] = 1; src_flag[3] = 1;      // sources 3 and 5
        src_en[2] = 1; src_en[4] = 1;
        step(3);
        chk("R2 held by I", irq_req, 0);
        src_en[2] = 0; src_en[4] = 0;
        wr_mask(0, 1);
        step(2);
        chk("R2 held by enable", irq_req, 0);

        // R3 default order
        cur_req = "R3";
        src_en[2] = 1; src_en[4] = 1;
        step(1);
        chk("R3 src_id", src_id, 3);
        chk("R3 vector_lo", vector_lo, 'hEE);

        // R12 hold while posted
        cur_req = "R12";
        src_flag[0] = 1; src_en[1] = 1;        // source 2 appears
        step(3);
        chk("R12 hold src_id", src_id, 3);
        chk("R12 hold req", irq_req, 1);
        do_ack();
        chk("R12 req drops", irq_req, 0);
        chk("R11 I set on take", i_mask, 1);
        src_flag = '0; src_en = '0;

        // R4 promotion of source 11
        cur_req = "R4";
        wr_sel('hDE);
        chk("R4 prio_sel", prio_sel, 'hDE);
        src_flag[1] = 1; src_flag[9] = 1; src_en[2] = 1; src_en[10] = 1;
        wr_mask(0, 1);
        step(1);
        chk("R4 src_id", src_id, 11);
        chk("R4 vector_lo", vector_lo, 'hDE);
        do_ack();
        src_flag = '0; src_en = '0;

        // R5 write ignored with I clear
        cur_req = "R5";
        wr_mask(0, 1);
        wr_sel('hF1);
        step(1);
        chk("R5 prio_sel kept", prio_sel, 'hDE);
        wr_mask(1, 1);

        // R6 unmatched value
        cur_req = "R6";
        wr_sel('h21);
        chk("R6 prio_sel", prio_sel, 'h20);
        src_flag[1] = 1; src_flag[9] = 1; src_en[2] = 1; src_en[10] = 1;
        wr_mask(0, 1);
        step(1);
        chk("R6 default wins", src_id, 3);
        do_ack();
        src_flag = '0; src_en = '0;

        // R7 level pin
        cur_req = "R7";
        src_en[0] = 1; irq_n = 0;
        wr_mask(0, 1);
        step(1);
        chk("R7 src_id", src_id, 1);
        chk("R7 vector_lo", vector_lo, 'hF2);
        irq_n = 1;
        do_ack();

        // R8 edge pin latched while I set
        cur_req = "R8";
        irq_edge_mode = 1;
        step(1);
        irq_n = 0; step(1); irq_n = 1;
        step(2);
        chk("R8 no req under I", irq_req, 0);
        wr_mask(0, 1);
        step(1);
        chk("R8 latched src", src_id, 1);
        chk("R8 latched req", irq_req, 1);
        do_ack();
        wr_mask(0, 1);
        step(2);
        chk("R8 latch cleared", irq_req, 0);
        wr_mask(1, 1);
        src_en = '0;

        // R10 X cannot be set again
        cur_req = "R10";
        wr_mask(1, 0);
        chk("R10 X cleared", x_mask, 0);
        wr_mask(1, 1);
        chk("R10 X stays clear", x_mask, 0);
        wr_mask(0, 0);
        chk("R10 I writable", i_mask, 0);
        wr_mask(1, 0);
        chk("R10 I set again", i_mask, 1);

        // R9 non-maskable request ignores I and outranks maskables
        cur_req = "R9";
        src_flag[1] = 1; src_en[2] = 1;
        xirq_n = 0;
        step(1);
        chk("R9 src_id", src_id, 0);
        chk("R9 vector_lo", vector_lo, 'hF4);
        cur_req = "R11";
        do_ack();
        chk("R11 X set on take", x_mask, 1);
        chk("R11 I set on take", i_mask, 1);
        cur_req = "R9";
        step(3);
        chk("R9 masked by X", irq_req, 0);
        xirq_n = 1; src_flag = '0; src_en = '0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule